// File: doc/BRIEF.md
# JTAG scan command engine

This block turns a stream of command and payload bytes into JTAG activity on one of eight scan ports. A host pushes bytes into an 8-byte write queue through three write widths: one, two or four bytes per write, stored lowest byte first. A sequencer pops the bytes one at a time and interprets them. It runs two kinds of command. The first walks a short TMS path. The second shifts a bit string into TDI while sampling TDO, and it can pack the TDO bits into 32-bit words that the host reads from a small word queue.

The host chooses the active scan port by writing a one-hot enable mask. The clock, mode and data lines are driven only on that port. A separate control write sets the target's test-reset line. A status word shows the host whether a command is still running and how many bytes are waiting in the write queue, so the host can poll it until the block is idle.

TCK is a fixed division of the system clock. Each TCK period carries one bit. TMS and TDI change only while TCK is low, and TDO is sampled on the rising edge of TCK.

Top module: `jscan_engine`

## Requirements
- R1: `wr_size` 0, 1 and 2 (3 behaves as 2) push 1, 2 and 4 bytes of `wr_data`, lowest byte first. `wr_ready` is low while the queue has fewer free bytes than the write needs. A write made while `wr_ready` is low is not taken, and the host keeps it pending until `wr_ready` rises, so no byte is lost.
- R2: `status` bit 31 is set while a command is being executed. Bits 30:28 give the write-queue fill level, limited to 7. Bit 1 mirrors the asserted test-reset. All other bits are zero. The block is idle when bits 31:28 are all zero.
- R3: A byte with bit 7 clear is a TMS walk. Bits 5:0 are sent LSB first, one per TCK period, up to but not including the highest set bit. Bit 6 has no effect. TDI is 0 during the walk. For example, 0x3F gives five periods with TMS=1, 0x12 gives TMS 0,1,0,0, and 0x01 gives no TCK period.
- R4: A byte with bit 7 set is a shift command. The next byte holds L, and the command shifts L+1 bits. These bits come from the following ceil((L+1)/8) bytes, each byte sent LSB first. TMS is 0 on every shifted bit, including the last one.
- R5: If bit 2 of the shift command byte is set, the TDO bits are packed LSB first into 32-bit words. A word is queued after every 32 bits and at the end of the command, with unused upper bits set to zero. If bit 2 is clear, no word is queued.
- R6: A TCK period lasts 2*TCK_HALF system clocks: TCK_HALF clocks low, then TCK_HALF clocks high. TMS and TDI change only while TCK is low. TDO is sampled when TCK rises.
- R7: A write to the port mask with zero or one bit set is applied. A write with two or more bits set is ignored. TCK, TMS and TDI are driven only on the enabled port and are 0 on all others. TDO is taken from the enabled port.
- R8: A control write of 0x02 pulls `trst_n_o` low. A control write of any other value releases it.
- R9: `rd_valid` is high while a captured word is queued, and `rd_data` shows the oldest one. `rd_en` pops that word. When the word queue is full, the shifter holds TCK high on the bit that must queue a word, and waits until there is room. No word is dropped.
- R10: After reset, `status` is 0, `wr_ready` is 1, `rd_valid` is 0, all TCK outputs are 0, `trst_n_o` is 1 and no port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write into the command queue |
| wr_size | input | 2 | Write width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wr_data | input | 32 | Write data, lowest byte first |
| wr_ready | output | 1 | Queue has room for a write of width `wr_size` |
| rd_en | input | 1 | Pop one captured word |
| rd_data | output | 32 | Oldest captured word |
| rd_valid | output | 1 | A captured word is available |
| en_wr | input | 1 | Write the port mask |
| en_data | input | NPORT | Port mask value |
| ctl_wr | input | 1 | Write the test-reset control |
| ctl_data | input | 8 | Control value (0x02 asserts the reset) |
| status | output | 32 | Busy, queue level and test-reset state |
| tck_o | output | NPORT | TCK per port |
| tms_o | output | NPORT | TMS per port |
| tdi_o | output | NPORT | TDI per port |
| tdo_i | input | NPORT | TDO per port |
| trst_n_o | output | 1 | Active-low test reset to the target |

## Verification
The assertions check on every cycle that:
- TMS and TDI stay stable while TCK is high.
- At most one port carries TCK.
- The port mask never has more than one bit set.
- Neither queue goes past its depth.
- A refused write never raises the queue fill.
- A word is never queued into a full word queue.
- Busy is set whenever TCK runs.

Only the bench scenarios can show the bit order and count of a TMS walk and of a shift. They also show that:
- Mixed write widths put the payload together in the right order.
- The captured words hold the right TDO bits, with the upper bits cleared.
- Back-pressure on both queues loses nothing.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEN,
        ST_LOAD,
        ST_CLK
    } jscan_state_e;

    localparam int CMD_KIND_BIT = 7;
    localparam int CAPTURE_BIT  = 2;

    // Number of TMS periods in a walk: index of the highest set bit.
    function automatic logic [2:0] walk_length(input logic [5:0] path);
        logic [2:0] hi;
        hi = 3'd0;
        for (int i = 0; i < 6; i++) begin
            if (path[i]) hi = 3'(i);
        end
        return hi;
    endfunction

endpackage

// File: rtl/jscan_bytefifo.sv
module jscan_bytefifo #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    output logic          space_ok,
    input  logic          pop,
    output logic [7:0]    pop_data,
    output logic          nonempty,
    output logic [CW-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         count;
    } bf_t;

    bf_t r_q, r_d;
    logic [2:0] taken;
    logic       pop_ok;

    assign space_ok = (CW'(DEPTH) - r_q.count) >= CW'(push_n);
    assign pop_data = r_q.mem[r_q.rp];
    assign nonempty = r_q.count != '0;
    assign level    = r_q.count;

    always_comb begin
        r_d    = r_q;
        taken  = (push && space_ok) ? push_n : 3'd0;
        pop_ok = pop && (r_q.count != '0);
        for (int i = 0; i < 4; i++) begin
            if (i < int'(taken)) begin
                r_d.mem[AW'(int'(r_q.wp) + i)] = push_data[8*i +: 8];
            end
        end
        r_d.wp    = r_q.wp + AW'(taken);
        r_d.rp    = r_q.rp + AW'(pop_ok);
        r_d.count = r_q.count + CW'(taken) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= CW'(DEPTH));

    p_refused_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !space_ok) |=> (r_q.count <= $past(r_q.count)));

endmodule

// File: rtl/jscan_wordfifo.sv
module jscan_wordfifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           count;
    } wf_t;

    wf_t  r_q, r_d;
    logic do_push, do_pop;

    assign full  = r_q.count == CW'(DEPTH);
    assign valid = r_q.count != '0;
    assign dout  = r_q.mem[r_q.rp];

    always_comb begin
        r_d     = r_q;
        do_push = push && !full;
        do_pop  = pop && valid;
        if (do_push) begin
            r_d.mem[r_q.wp] = din;
            r_d.wp = (r_q.wp == AW'(DEPTH - 1)) ? '0 : r_q.wp + AW'(1);
        end
        if (do_pop) begin
            r_d.rp = (r_q.rp == AW'(DEPTH - 1)) ? '0 : r_q.rp + AW'(1);
        end
        r_d.count = r_q.count + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_rf_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= CW'(DEPTH));

endmodule

// File: rtl/jscan_shifter.sv
module jscan_shifter
    import jscan_pkg::*;
#(
    parameter int TCK_HALF = 2,
    parameter int CAPW     = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    output logic            byte_pop,
    input  logic            tdo,
    output logic            tck,
    output logic            tms,
    output logic            tdi,
    output logic            cap_push,
    output logic [CAPW-1:0] cap_word,
    input  logic            cap_full,
    output logic            busy
);
    localparam int DW  = $clog2(2 * TCK_HALF);
    localparam int CCW = $clog2(CAPW + 1);
    localparam int CAW = $clog2(CAPW);

    typedef struct packed {
        jscan_state_e    st;
        logic            mode_tdi;
        logic [5:0]      path;
        logic [2:0]      path_left;
        logic [7:0]      sh;
        logic [3:0]      byte_left;
        logic [8:0]      remain;
        logic            capture;
        logic [CAPW-1:0] cap;
        logic [CCW-1:0]  cap_cnt;
        logic [DW-1:0]   div;
    } sq_t;

    sq_t  r_q, r_d;
    logic sample_pt, bit_end, need_push;

    assign tck      = (r_q.st == ST_CLK) && (r_q.div >= DW'(TCK_HALF));
    assign tms      = (r_q.st == ST_CLK) && !r_q.mode_tdi && r_q.path[0];
    assign tdi      = (r_q.st == ST_CLK) && r_q.mode_tdi && r_q.sh[0];
    assign cap_word = r_q.cap;
    assign busy     = r_q.st != ST_IDLE;

    always_comb begin
        r_d       = r_q;
        byte_pop  = 1'b0;
        cap_push  = 1'b0;
        sample_pt = r_q.div == DW'(TCK_HALF - 1);
        bit_end   = r_q.div == DW'(2 * TCK_HALF - 1);
        need_push = r_q.mode_tdi && r_q.capture &&
                    ((r_q.cap_cnt == CCW'(CAPW)) || (r_q.remain == 9'd1));
        case (r_q.st)
            ST_IDLE: begin
                if (byte_valid) begin
                    byte_pop = 1'b1;
                    if (byte_data[CMD_KIND_BIT]) begin
                        r_d.capture = byte_data[CAPTURE_BIT];
                        r_d.st      = ST_LEN;
                    end else begin
                        r_d.path      = byte_data[5:0];
                        r_d.path_left = walk_length(byte_data[5:0]);
                        r_d.mode_tdi  = 1'b0;
                        r_d.div       = '0;
                        if (r_d.path_left != 3'd0) r_d.st = ST_CLK;
                    end
                end
            end
            ST_LEN: begin
                if (byte_valid) begin
                    byte_pop   = 1'b1;
                    r_d.remain = {1'b0, byte_data} + 9'd1;
                    r_d.st     = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (byte_valid) begin
                    byte_pop      = 1'b1;
                    r_d.sh        = byte_data;
                    r_d.byte_left = (r_q.remain >= 9'd8) ? 4'd8 : r_q.remain[3:0];
                    r_d.mode_tdi  = 1'b1;
                    r_d.div       = '0;
                    r_d.st        = ST_CLK;
                end
            end
            default: begin
                if (sample_pt && r_q.mode_tdi && r_q.capture) begin
                    r_d.cap[r_q.cap_cnt[CAW-1:0]] = tdo;
                    r_d.cap_cnt = r_q.cap_cnt + CCW'(1);
                end
                if (!bit_end) begin
                    r_d.div = r_q.div + DW'(1);
                end else if (!(need_push && cap_full)) begin
                    r_d.div = '0;
                    if (need_push) begin
                        cap_push    = 1'b1;
                        r_d.cap     = '0;
                        r_d.cap_cnt = '0;
                    end
                    if (r_q.mode_tdi) begin
                        r_d.sh        = r_q.sh >> 1;
                        r_d.remain    = r_q.remain - 9'd1;
                        r_d.byte_left = r_q.byte_left - 4'd1;
                        if (r_q.remain == 9'd1)         r_d.st = ST_IDLE;
                        else if (r_q.byte_left == 4'd1) r_d.st = ST_LOAD;
                    end else begin
                        r_d.path      = r_q.path >> 1;
                        r_d.path_left = r_q.path_left - 3'd1;
                        if (r_q.path_left == 3'd1) r_d.st = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_lines_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> ($stable(tdi) && $stable(tms)));

    p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cap_cnt <= CCW'(CAPW));

    p_no_push_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> !cap_full);

    p_shift_tms_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && r_q.mode_tdi) |-> !tms);

endmodule

// File: rtl/jscan_engine.sv
module jscan_engine #(
    parameter int NPORT    = 8,
    parameter int WF_DEPTH = 8,
    parameter int RF_DEPTH = 4,
    parameter int TCK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_size,
    input  logic [31:0]      wr_data,
    output logic             wr_ready,
    input  logic             rd_en,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    input  logic             en_wr,
    input  logic [NPORT-1:0] en_data,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_data,
    output logic [31:0]      status,
    output logic [NPORT-1:0] tck_o,
    output logic [NPORT-1:0] tms_o,
    output logic [NPORT-1:0] tdi_o,
    input  logic [NPORT-1:0] tdo_i,
    output logic             trst_n_o
);
    localparam int WCW = $clog2(WF_DEPTH + 1);

    typedef struct packed {
        logic [NPORT-1:0] port_en;
        logic             trst;
    } top_t;

    top_t r_q, r_d;

    logic [2:0]     nbytes;
    logic [WCW-1:0] wf_level;
    logic           wf_nonempty, wf_pop;
    logic [7:0]     wf_byte;
    logic           sq_tck, sq_tms, sq_tdi, sq_busy, sel_tdo;
    logic           cap_push, cap_full;
    logic [31:0]    cap_word;
    logic [2:0]     fill3;

    always_comb begin
        case (wr_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    jscan_bytefifo #(.DEPTH(WF_DEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .push_n(nbytes), .push_data(wr_data), .space_ok(wr_ready),
        .pop(wf_pop), .pop_data(wf_byte), .nonempty(wf_nonempty), .level(wf_level)
    );

    assign sel_tdo = |(tdo_i & r_q.port_en);

    jscan_shifter #(.TCK_HALF(TCK_HALF), .CAPW(32)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(wf_nonempty), .byte_data(wf_byte), .byte_pop(wf_pop),
        .tdo(sel_tdo), .tck(sq_tck), .tms(sq_tms), .tdi(sq_tdi),
        .cap_push(cap_push), .cap_word(cap_word), .cap_full(cap_full),
        .busy(sq_busy)
    );

    jscan_wordfifo #(.DEPTH(RF_DEPTH), .W(32)) u_rq (
        .clk(clk), .rst_n(rst_n),
        .push(cap_push), .din(cap_word), .full(cap_full),
        .pop(rd_en), .dout(rd_data), .valid(rd_valid)
    );

    always_comb begin
        r_d = r_q;
        if (en_wr && ($countones(en_data) <= 1)) r_d.port_en = en_data;
        if (ctl_wr) r_d.trst = (ctl_data == 8'h02);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fill3 = (wf_level > WCW'(7)) ? 3'd7 : wf_level[2:0];

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign tck_o[p] = r_q.port_en[p] & sq_tck;
            assign tms_o[p] = r_q.port_en[p] & sq_tms;
            assign tdi_o[p] = r_q.port_en[p] & sq_tdi;
        end
    endgenerate

    assign status   = {sq_busy, fill3, 26'd0, r_q.trst, 1'b0};
    assign trst_n_o = !r_q.trst;

    p_mask_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.port_en));

    p_single_tck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tck_o));

    p_busy_with_tck_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tck_o) |-> status[31]);

    p_trst_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (trst_n_o == ($past(ctl_data) != 8'h02)));

endmodule

// File: tb/sim_jscan_engine.sv
`timescale 1ns/1ps
module sim_jscan_engine;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, en_wr = 1'b0, ctl_wr = 1'b0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  en_data = '0, ctl_data = '0;
    logic        wr_ready, rd_valid, trst_n_o;
    logic [31:0] rd_data, status;
    logic [7:0]  tck_o, tms_o, tdi_o, tdo_i;

    always #4 clk = ~clk;

    jscan_engine u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .en_wr(en_wr), .en_data(en_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .status(status), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i),
        .trst_n_o(trst_n_o)
    );

    int n_chk = 0, n_bad = 0;
    int edges = 0;
    logic [255:0] rec_tdi, rec_tms, tdo_pat;
    logic [7:0]   exp_mask = 8'h80;
    logic         stray = 1'b0, prev_tck = 1'b0, saw_stall = 1'b0, done = 1'b0;
    logic [2:0]   stall_fill = '0;

    assign tdo_i = {8{(edges < 256) ? tdo_pat[edges] : 1'b0}};

    always @(negedge clk) begin
        if ((tck_o & ~exp_mask) != 8'h00) stray <= 1'b1;
        if ((|tck_o) && !prev_tck) begin
            rec_tdi[edges] <= |tdi_o;
            rec_tms[edges] <= |tms_o;
            edges <= edges + 1;
        end
        prev_tck <= |tck_o;
    end

    localparam int NV = 6;
    localparam int          V_LEN [NV] = '{1, 8, 13, 24, 25, 32};
    localparam logic [31:0] V_TDI [NV] = '{32'h1, 32'hA5, 32'h1B3C, 32'hC3_5A96, 32'h1F0_0F0F, 32'hDEAD_BEEF};
    localparam logic [31:0] V_TDO [NV] = '{32'hFFFF_FFFF, 32'h0000_005A, 32'h1234_5678, 32'hFFFF_0000, 32'h8765_4321, 32'hCAFE_F00D};

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_size = sz; wr_data = d;
        while (!wr_ready) begin
            saw_stall = 1'b1;
            stall_fill = status[30:28];
            @(negedge clk);
        end
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_shift(input logic [7:0] cmd, input int n, input logic [255:0] d);
        int nb, idx;
        nb = (n + 7) / 8;
        idx = 0;
        wr(2'd1, {16'h0, 8'(n - 1), cmd});
        while (nb - idx >= 4) begin
            wr(2'd2, d[idx*8 +: 32]);
            idx += 4;
        end
        if (nb - idx >= 2) begin
            wr(2'd1, {16'h0, d[idx*8 +: 16]});
            idx += 2;
        end
        if (nb - idx == 1) wr(2'd0, {24'h0, d[idx*8 +: 8]});
    endtask

    task automatic clear_trace();
        @(negedge clk);
        edges = 0; rec_tdi = '0; rec_tms = '0; stray = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (status[31:28] == 4'h0) break;
        end
    endtask

    task automatic rd_word(output logic [31:0] w);
        w = 32'hx;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rd_valid) break;
        end
        w = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_trace(input int n, input logic [255:0] d, input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) if (rec_tdi[k] !== d[k]) bad++;
        chk(bad == 0, {tag, " tdi stream"}, 64'(bad), 64'd0);
        chk(edges == n, {tag, " tck periods"}, 64'(edges), 64'(n));
        chk(rec_tms == '0, {tag, " tms low"}, 64'(rec_tms[63:0]), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [63:0] m;
        logic [255:0] big;
        tdo_pat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(status == 32'h0, "R10 status", 64'(status), 64'd0);
        chk(wr_ready == 1'b1, "R10 wr_ready", 64'(wr_ready), 64'd1);
        chk(rd_valid == 1'b0, "R10 rd_valid", 64'(rd_valid), 64'd0);
        chk(tck_o == 8'h00 && trst_n_o, "R10 tck/trst", 64'({tck_o, trst_n_o}), 64'h1);

        // R7 select port 7, R8 test reset
        @(negedge clk); en_data = 8'h80; en_wr = 1'b1; @(negedge clk); en_wr = 1'b0;
        ctl_data = 8'h02; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
        chk(trst_n_o == 1'b0, "R8 assert", 64'(trst_n_o), 64'd0);
        chk(status == 32'h2, "R2 trst bit", 64'(status), 64'h2);
        ctl_data = 8'h00; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
        chk(trst_n_o == 1'b1, "R8 release", 64'(trst_n_o), 64'd1);

        // R3 TMS walks
        clear_trace(); wr(2'd0, 32'h3F); wait_idle();
        chk(edges == 5 && rec_tms[4:0] == 5'h1F, "R3 walk 0x3F", 64'({edges[7:0], rec_tms[7:0]}), 64'h051F);
        chk(rec_tdi[7:0] == 8'h0, "R3 tdi low", 64'(rec_tdi[7:0]), 64'd0);
        clear_trace(); wr(2'd0, 32'h12); wait_idle();
        chk(edges == 4 && rec_tms[3:0] == 4'b0010, "R3 walk 0x12", 64'({edges[7:0], rec_tms[7:0]}), 64'h0402);
        clear_trace(); wr(2'd0, 32'h52); wait_idle();
        chk(edges == 4 && rec_tms[3:0] == 4'b0010, "R3 flag bit ignored", 64'({edges[7:0], rec_tms[7:0]}), 64'h0402);
        clear_trace(); wr(2'd0, 32'h01); wait_idle();
        chk(edges == 0, "R3 empty walk", 64'(edges), 64'd0);

        // R4 R5 R1 vector table: capture shifts of various lengths
        for (int v = 0; v < NV; v++) begin
            clear_trace();
            tdo_pat = {224'h0, V_TDO[v]};
            send_shift(8'h84, V_LEN[v], {224'h0, V_TDI[v]});
            wait_idle();
            m = (64'd1 << V_LEN[v]) - 64'd1;
            chk_trace(V_LEN[v], {224'h0, V_TDI[v]}, "R4 vector");
            rd_word(w);
            chk(w == 32'(64'(V_TDO[v]) & m), "R5 captured word", 64'(w), 64'(V_TDO[v]) & m);
        end

        // R5 no capture when bit 2 clear; 40-bit shift
        clear_trace();
        big = {192'h0, 64'h00A1_B2C3_D4E5_F607};
        send_shift(8'h80, 40, big);
        wait_idle();
        chk_trace(40, big, "R4 40-bit");
        chk(rd_valid == 1'b0, "R5 no capture", 64'(rd_valid), 64'd0);

        // R1 R2 back-pressure on 128-bit capture shift
        clear_trace(); saw_stall = 1'b0;
        big = {128'h0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210};
        tdo_pat = {128'h0, 128'h5555_AAAA_3333_CCCC_0F0F_F0F0_1234_8765};
        send_shift(8'h84, 128, big);
        chk(saw_stall == 1'b1, "R1 write held off", 64'(saw_stall), 64'd1);
        chk(stall_fill >= 3'd5, "R2 fill level at stall", 64'(stall_fill), 64'd5);
        wait_idle();
        chk_trace(128, big, "R1 128-bit no loss");
        for (int k = 0; k < 4; k++) begin
            rd_word(w);
            chk(w == tdo_pat[32*k +: 32], "R5 multiword", 64'(w), 64'(tdo_pat[32*k +: 32]));
        end

        // R9 word queue full stalls the shifter
        clear_trace();
        big = {96'h0, 160'hF00D_1111_2222_3333_4444_5555_6666_7777_8888_9999};
        tdo_pat = {96'h0, 160'hABCD_0001_0002_0003_0004_0005_0006_0007_0008_0009};
        send_shift(8'h84, 160, big);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (edges >= 160) break;
        end
        repeat (20) @(negedge clk);
        chk(status[31] == 1'b1 && edges == 160, "R9 stall on full", 64'({status[31], edges[15:0]}), 64'h100A0);
        for (int k = 0; k < 5; k++) begin
            rd_word(w);
            chk(w == tdo_pat[32*k +: 32], "R9 word order", 64'(w), 64'(tdo_pat[32*k +: 32]));
        end
        wait_idle();
        chk(status == 32'h0, "R2 idle after drain", 64'(status), 64'd0);

        // R7 multi-bit mask ignored, then switch to port 0
        @(negedge clk); en_data = 8'h81; en_wr = 1'b1; @(negedge clk); en_wr = 1'b0;
        clear_trace(); wr(2'd0, 32'h3F); wait_idle();
        chk(stray == 1'b0 && edges == 5, "R7 multi-bit mask ignored", 64'({stray, edges[7:0]}), 64'h005);
        @(negedge clk); en_data = 8'h01; en_wr = 1'b1; @(negedge clk); en_wr = 1'b0;
        exp_mask = 8'h01;
        clear_trace(); wr(2'd0, 32'h3F); wait_idle();
        chk(stray == 1'b0 && edges == 5, "R7 port 0 only", 64'({stray, edges[7:0]}), 64'h005);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule